// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block is the vertical half of a display pipe's timing generator. It counts scanlines, one per `line_tick` pulse from the horizontal timing logic. It also decides which line ends the frame. In fixed-refresh mode the frame has a programmed total length, and vertical blank begins at a programmed line. In variable-refresh mode the end of the frame floats. The frame is held in vertical blank until software posts a "push" or a maximum frame length is reached. After that a fixed-length exit sequence runs and the next frame begins.

The block also produces the strobe that tells the pipe's double-buffered registers to take their pending values. The timing registers of the block itself are double-buffered on that same strobe. In fixed mode the strobe fires on entry to the blank line. In variable mode it fires on the first line of the exit sequence. Software programs the block through a plain register write port with a combinational read port. The length registers take the value minus one, and readback returns exactly what was stored.

The exit sequence is `exit_len = guardband + frame_start_delay + 1` lines long. The earliest line on which it may start is `flip_eff - exit_len`. The latest is `vmax - exit_len`. A push seen before the earliest line is held until that line. A push seen inside the window starts the exit on the next line. Without a push, the exit starts on the latest line.

Top module: `vrr_vtimer`

## Requirements
- R1: After reset the line counter is 0, and `vblank`, `frame_start`, `latch_stb` and `cfg_error` are 0. Registers read back as 0, except BLANK_LINE = `DEF_BLANK` and FIX_TOTAL = `DEF_TOTAL-1`.
- R2: `line_num` changes only at a clock edge where `line_tick` was 1. `frame_start` is a one-cycle pulse, raised at the tick that wraps the counter to 0.
- R3: In fixed mode a frame is FIX_TOTAL+1 lines long. `vblank` is 1 while `line_num >= BLANK_LINE`. `latch_stb` pulses at the tick that enters line BLANK_LINE.
- R4: In variable mode, `exit_len = guard + (fsd_m1+1) + 1`. `flip_eff` is FLIPLINE+1 when flip-enable is set, else MINLEN+2. The exit may start on lines `flip_eff-exit_len` to `(MAXLEN+1)-exit_len`. An exit that starts on line E gives a frame of E+exit_len lines, and `latch_stb` pulses on entry to line E.
- R5: If no push is pending, the exit starts on the latest line, so the frame is MAXLEN+1 lines long.
- R6: A push posted before the earliest line is held, and the exit starts exactly on the earliest line.
- R7: A push posted while the counter is on line L inside the window starts the exit on line L+1.
- R8: The push register reads back as {send, enable} in bits 1 and 0. The send bit clears itself when the exit consumes the push.
- R9: A write to the push register sets send only if the same write sets the enable bit (bit 0). A send-only write leaves send 0 and does not shorten the frame.
- R10: `cfg_error` is 1 and the block runs in fixed mode when the active control enable is 1 and any of these holds: MINLEN+1 >= MAXLEN+1; flip-enable is set and FLIPLINE+1 < MINLEN+2; `flip_eff` > MAXLEN+1; or `exit_len >= flip_eff`.
- R11: The register map is:
  - 0 MINLEN (value minus one)
  - 1 MAXLEN (value minus one)
  - 2 FLIPLINE (value minus one)
  - 3 CONTROL: bit 0 enable, bit 1 flip-enable, bits 3:2 frame-start delay minus one, bits 11:4 guard
  - 4 PUSH
  - 5 BLANK_LINE
  - 6 FIX_TOTAL (value minus one)

  Each register reads back what was written, masked to its width.
- R12: Registers 0 to 3, 5 and 6 act only after the next `latch_stb`. Writing 0 to CONTROL and PUSH returns the block to fixed timing after that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One pulse per scanline |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (write and read) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| line_num | output | LINE_W | Current scanline |
| vblank | output | 1 | Vertical blank active |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |
| latch_stb | output | 1 | One-cycle double-buffer latch strobe |
| cfg_error | output | 1 | Active variable-refresh configuration is invalid |

## Verification
The bench targets these corner cases:
- A push posted far ahead of the window must wait for the earliest line. A design that acts on it at once gives a frame shorter than the flip line.
- A push inside the window must start the exit one line later. Being off by one in the decision shifts both the frame length and the line of the latch strobe.
- Without a push the frame must stop at the maximum length. A design that waits forever would hang the counter.
- A send-only push write, and a timing register written just after the latch, must have no effect until the proper point.
- Each invalid configuration must fall back to fixed timing. A design that skips the check would produce frames longer or shorter than the fixed total.

// File: rtl/vrr_vt_pkg.sv
package vrr_vt_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MINLEN  = 3'd0,
    RA_MAXLEN  = 3'd1,
    RA_FLIP    = 3'd2,
    RA_CTRL    = 3'd3,
    RA_PUSH    = 3'd4,
    RA_BLANK   = 3'd5,
    RA_FIXTOT  = 3'd6
  } reg_addr_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_FLIP_BIT = 1;
  localparam int unsigned CTL_FSD_LSB  = 2;
  localparam int unsigned CTL_FSD_W    = 2;
  localparam int unsigned CTL_GB_LSB   = 4;

  localparam int unsigned PUSH_EN_BIT   = 0;
  localparam int unsigned PUSH_SEND_BIT = 1;
endpackage

// File: rtl/vrr_vt_regs.sv
module vrr_vt_regs
  import vrr_vt_pkg::*;
#(
  parameter int unsigned LINE_W    = 12,
  parameter int unsigned GUARD_W   = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEF_BLANK = 15,
  parameter int unsigned DEF_TOTAL = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic                 latch_now,
  input  logic                 consume,
  output logic [LINE_W-1:0]    a_minlen_m1,
  output logic [LINE_W-1:0]    a_maxlen_m1,
  output logic [LINE_W-1:0]    a_flip_m1,
  output logic                 a_en,
  output logic                 a_flip_en,
  output logic [CTL_FSD_W-1:0] a_fsd_m1,
  output logic [GUARD_W-1:0]   a_guard,
  output logic [LINE_W-1:0]    a_blank,
  output logic [LINE_W-1:0]    a_fixtot_m1,
  output logic                 send_q
);
  localparam int unsigned CTL_W = CTL_GB_LSB + GUARD_W;
  localparam logic [LINE_W-1:0] RST_BLANK = LINE_W'(DEF_BLANK);
  localparam logic [LINE_W-1:0] RST_TOT   = LINE_W'(DEF_TOTAL - 1);

  logic [LINE_W-1:0]    p_minlen_m1, p_maxlen_m1, p_flip_m1, p_blank, p_fixtot_m1;
  logic                 p_en, p_flip_en, push_en_q;
  logic [CTL_FSD_W-1:0] p_fsd_m1;
  logic [GUARD_W-1:0]   p_guard;
  reg_addr_e            waddr;

  assign waddr = reg_addr_e'(addr);

  // pending copy, written by software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_minlen_m1 <= '0;
      p_maxlen_m1 <= '0;
      p_flip_m1   <= '0;
      p_en        <= 1'b0;
      p_flip_en   <= 1'b0;
      p_fsd_m1    <= '0;
      p_guard     <= '0;
      p_blank     <= RST_BLANK;
      p_fixtot_m1 <= RST_TOT;
    end else if (wr) begin
      case (waddr)
        RA_MINLEN: p_minlen_m1 <= wdata[LINE_W-1:0];
        RA_MAXLEN: p_maxlen_m1 <= wdata[LINE_W-1:0];
        RA_FLIP:   p_flip_m1   <= wdata[LINE_W-1:0];
        RA_CTRL: begin
          p_en      <= wdata[CTL_EN_BIT];
          p_flip_en <= wdata[CTL_FLIP_BIT];
          p_fsd_m1  <= wdata[CTL_FSD_LSB +: CTL_FSD_W];
          p_guard   <= wdata[CTL_GB_LSB +: GUARD_W];
        end
        RA_BLANK:  p_blank     <= wdata[LINE_W-1:0];
        RA_FIXTOT: p_fixtot_m1 <= wdata[LINE_W-1:0];
        default: ;
      endcase
    end
  end

  // active copy, taken at the latch strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_minlen_m1 <= '0;
      a_maxlen_m1 <= '0;
      a_flip_m1   <= '0;
      a_en        <= 1'b0;
      a_flip_en   <= 1'b0;
      a_fsd_m1    <= '0;
      a_guard     <= '0;
      a_blank     <= RST_BLANK;
      a_fixtot_m1 <= RST_TOT;
    end else if (latch_now) begin
      a_minlen_m1 <= p_minlen_m1;
      a_maxlen_m1 <= p_maxlen_m1;
      a_flip_m1   <= p_flip_m1;
      a_en        <= p_en;
      a_flip_en   <= p_flip_en;
      a_fsd_m1    <= p_fsd_m1;
      a_guard     <= p_guard;
      a_blank     <= p_blank;
      a_fixtot_m1 <= p_fixtot_m1;
    end
  end

  // push register: a write wins over consumption in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_en_q <= 1'b0;
      send_q    <= 1'b0;
    end else if (wr && waddr == RA_PUSH) begin
      push_en_q <= wdata[PUSH_EN_BIT];
      send_q    <= wdata[PUSH_EN_BIT] & wdata[PUSH_SEND_BIT];
    end else if (consume) begin
      send_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (waddr)
      RA_MINLEN: rdata[LINE_W-1:0] = p_minlen_m1;
      RA_MAXLEN: rdata[LINE_W-1:0] = p_maxlen_m1;
      RA_FLIP:   rdata[LINE_W-1:0] = p_flip_m1;
      RA_CTRL:   rdata[CTL_W-1:0]  = {p_guard, p_fsd_m1, p_flip_en, p_en};
      RA_PUSH: begin
        rdata[PUSH_EN_BIT]   = push_en_q;
        rdata[PUSH_SEND_BIT] = send_q;
      end
      RA_BLANK:  rdata[LINE_W-1:0] = p_blank;
      RA_FIXTOT: rdata[LINE_W-1:0] = p_fixtot_m1;
      default:   rdata = '0;
    endcase
  end

  wire unused_wdata = ^wdata;
endmodule

// File: rtl/vrr_vt_bounds.sv
module vrr_vt_bounds #(
  parameter int unsigned LINE_W  = 12,
  parameter int unsigned GUARD_W = 8,
  parameter int unsigned FSD_W   = 2,
  parameter int unsigned EXT_W   = 14
) (
  input  logic [LINE_W-1:0]  a_minlen_m1,
  input  logic [LINE_W-1:0]  a_maxlen_m1,
  input  logic [LINE_W-1:0]  a_flip_m1,
  input  logic               a_en,
  input  logic               a_flip_en,
  input  logic [FSD_W-1:0]   a_fsd_m1,
  input  logic [GUARD_W-1:0] a_guard,
  output logic               vrr_on,
  output logic               cfg_err,
  output logic [EXT_W-1:0]   exit_len,
  output logic [EXT_W-1:0]   early_ln,
  output logic [EXT_W-1:0]   late_ln,
  output logic [EXT_W-1:0]   maxlen
);
  logic [EXT_W-1:0] minlen, flip, flip_eff;
  logic             ok;

  always_comb begin
    minlen   = EXT_W'(a_minlen_m1) + EXT_W'(1);
    maxlen   = EXT_W'(a_maxlen_m1) + EXT_W'(1);
    flip     = EXT_W'(a_flip_m1) + EXT_W'(1);
    flip_eff = a_flip_en ? flip : (minlen + EXT_W'(1));
    // guard + (delay_m1 + 1) + one inserted line
    exit_len = EXT_W'(a_guard) + EXT_W'(a_fsd_m1) + EXT_W'(2);
    ok = (minlen < maxlen) &&
         (flip_eff <= maxlen) &&
         (flip_eff >= minlen + EXT_W'(1)) &&
         (exit_len < flip_eff);
    early_ln = flip_eff - exit_len;
    late_ln  = maxlen - exit_len;
    vrr_on   = a_en & ok;
    cfg_err  = a_en & ~ok;
  end
endmodule

// File: rtl/vrr_vt_linegen.sv
module vrr_vt_linegen #(
  parameter int unsigned LINE_W = 12,
  parameter int unsigned EXT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              vrr_on,
  input  logic              send,
  input  logic [EXT_W-1:0]  exit_len,
  input  logic [EXT_W-1:0]  early_ln,
  input  logic [EXT_W-1:0]  late_ln,
  input  logic [EXT_W-1:0]  maxlen,
  input  logic [LINE_W-1:0] blank_ln,
  input  logic [LINE_W-1:0] fixtot_m1,
  output logic [LINE_W-1:0] line_q,
  output logic              vblank_q,
  output logic              fstart_q,
  output logic              latch_q,
  output logic              latch_now,
  output logic              consume
);
  logic [EXT_W-1:0]  nxt, line_x, end_q;
  logic              exiting_q, wrap, decide;
  logic [LINE_W-1:0] line_n;

  always_comb begin
    line_x = EXT_W'(line_q);
    nxt    = line_x + EXT_W'(1);
    if (vrr_on)
      wrap = exiting_q ? (line_x >= end_q) : (nxt >= maxlen);
    else
      wrap = (line_q >= fixtot_m1);
    decide = vrr_on && !exiting_q && (nxt >= early_ln) && (nxt <= late_ln) &&
             (send || nxt == late_ln);
    latch_now = tick && !wrap && (vrr_on ? decide : (nxt == EXT_W'(blank_ln)));
    consume   = latch_now && vrr_on;
    line_n    = wrap ? '0 : nxt[LINE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q    <= '0;
      vblank_q  <= 1'b0;
      fstart_q  <= 1'b0;
      latch_q   <= 1'b0;
      exiting_q <= 1'b0;
      end_q     <= '0;
    end else begin
      fstart_q <= tick && wrap;
      latch_q  <= latch_now;
      if (tick) begin
        line_q   <= line_n;
        vblank_q <= (line_n >= blank_ln);
        if (wrap)
          exiting_q <= 1'b0;
        else if (decide) begin
          exiting_q <= 1'b1;
          end_q     <= nxt + exit_len - EXT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vrr_vtimer.sv
module vrr_vtimer
  import vrr_vt_pkg::*;
#(
  parameter int unsigned LINE_W    = 12,
  parameter int unsigned GUARD_W   = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned DEF_BLANK = 15,
  parameter int unsigned DEF_TOTAL = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              frame_start,
  output logic              latch_stb,
  output logic              cfg_error
);
  localparam int unsigned EXT_W = ((LINE_W > GUARD_W) ? LINE_W : GUARD_W) + 2;

  logic [LINE_W-1:0]    a_minlen_m1, a_maxlen_m1, a_flip_m1, a_blank, a_fixtot_m1;
  logic                 a_en, a_flip_en, send_q, vrr_on, latch_now, consume;
  logic [CTL_FSD_W-1:0] a_fsd_m1;
  logic [GUARD_W-1:0]   a_guard;
  logic [EXT_W-1:0]     exit_len, early_ln, late_ln, maxlen;

  vrr_vt_regs #(
    .LINE_W(LINE_W), .GUARD_W(GUARD_W), .DATA_W(DATA_W),
    .DEF_BLANK(DEF_BLANK), .DEF_TOTAL(DEF_TOTAL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .latch_now(latch_now), .consume(consume),
    .a_minlen_m1(a_minlen_m1), .a_maxlen_m1(a_maxlen_m1), .a_flip_m1(a_flip_m1),
    .a_en(a_en), .a_flip_en(a_flip_en), .a_fsd_m1(a_fsd_m1), .a_guard(a_guard),
    .a_blank(a_blank), .a_fixtot_m1(a_fixtot_m1), .send_q(send_q)
  );

  vrr_vt_bounds #(
    .LINE_W(LINE_W), .GUARD_W(GUARD_W), .FSD_W(CTL_FSD_W), .EXT_W(EXT_W)
  ) u_bounds (
    .a_minlen_m1(a_minlen_m1), .a_maxlen_m1(a_maxlen_m1), .a_flip_m1(a_flip_m1),
    .a_en(a_en), .a_flip_en(a_flip_en), .a_fsd_m1(a_fsd_m1), .a_guard(a_guard),
    .vrr_on(vrr_on), .cfg_err(cfg_error), .exit_len(exit_len),
    .early_ln(early_ln), .late_ln(late_ln), .maxlen(maxlen)
  );

  vrr_vt_linegen #(.LINE_W(LINE_W), .EXT_W(EXT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .tick(line_tick), .vrr_on(vrr_on), .send(send_q),
    .exit_len(exit_len), .early_ln(early_ln), .late_ln(late_ln), .maxlen(maxlen),
    .blank_ln(a_blank), .fixtot_m1(a_fixtot_m1),
    .line_q(line_num), .vblank_q(vblank), .fstart_q(frame_start),
    .latch_q(latch_stb), .latch_now(latch_now), .consume(consume)
  );
endmodule

// File: rtl/vrr_vtimer_chk.sv
module vrr_vtimer_chk #(
  parameter int unsigned LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_tick,
  input logic [LINE_W-1:0] line_num,
  input logic              frame_start,
  input logic              latch_stb,
  input logic              send_q,
  input logic              consume,
  input logic              cfg_wr,
  input logic [2:0]        cfg_addr
);
  // R2: a new frame always begins on line 0
  assert_fs_line0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_num == '0));

  // R2: counter holds between line ticks
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_tick) |-> $stable(line_num));

  // R2: frame start only follows a tick
  assert_fs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(line_tick));

  // R12: latch strobe only follows a tick
  assert_latch_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> $past(line_tick));

  // R8: a consumed push leaves send clear unless rewritten
  assert_send_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !(cfg_wr && cfg_addr == 3'd4)) |=> !send_q);
endmodule

bind vrr_vtimer vrr_vtimer_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_num(line_num),
  .frame_start(frame_start), .latch_stb(latch_stb), .send_q(send_q),
  .consume(consume), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr)
);

// File: tb/vrr_vtimer_tb.sv
`timescale 1ns/1ps
module vrr_vtimer_tb;
  localparam int LW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [LW-1:0] line_num;
  logic        vblank, frame_start, latch_stb, cfg_error;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vrr_vtimer u_dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .line_num(line_num), .vblank(vblank), .frame_start(frame_start),
    .latch_stb(latch_stb), .cfg_error(cfg_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one scanline every three clocks
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 3;
    line_tick <= rst_n && (tdiv == 0);
  end

  // ---------------- behavioural reference model ----------------
  int p_min, p_max, p_flip, p_ctl, p_blank, p_tot;
  int a_min, a_max, a_flip, a_ctl, a_blank, a_tot;
  int m_send, m_pen, m_line, m_end;
  bit m_vbl, m_fs, m_lat, m_exit;

  function automatic void m_bounds(output bit vrr, output bit err,
                                   output int el, output int lo, output int hi,
                                   output int vmax);
    int vmin = a_min + 1;
    int flip = a_flip + 1;
    int en = a_ctl & 1;
    int fe = (a_ctl >> 1) & 1;
    int fsd = ((a_ctl >> 2) & 3) + 1;
    int gb = (a_ctl >> 4) & 255;
    int fl;
    bit ok;
    vmax = a_max + 1;
    el = gb + fsd + 1;
    fl = fe ? flip : vmin + 1;
    ok = (vmin < vmax) && (fl <= vmax) && (fl >= vmin + 1) && (el < fl);
    lo = fl - el;
    hi = vmax - el;
    vrr = en && ok;
    err = en && !ok;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      p_min = 0; p_max = 0; p_flip = 0; p_ctl = 0; p_blank = 15; p_tot = 19;
      a_min = 0; a_max = 0; a_flip = 0; a_ctl = 0; a_blank = 15; a_tot = 19;
      m_send = 0; m_pen = 0; m_line = 0; m_end = 0;
      m_vbl = 0; m_fs = 0; m_lat = 0; m_exit = 0;
    end else begin
      bit vrr, err, wrap, cons;
      int el, lo, hi, vmax, nx;
      m_bounds(vrr, err, el, lo, hi, vmax);
      m_fs = 0; m_lat = 0; cons = 0;
      if (line_tick) begin
        nx = m_line + 1;
        if (vrr) wrap = m_exit ? (m_line >= m_end) : (nx >= vmax);
        else     wrap = (m_line >= a_tot);
        if (wrap) begin
          m_line = 0; m_exit = 0; m_fs = 1;
        end else begin
          if (vrr) begin
            if (!m_exit && nx >= lo && nx <= hi && (m_send != 0 || nx == hi)) begin
              m_exit = 1; m_end = nx + el - 1; m_lat = 1; cons = 1;
            end
          end else if (nx == a_blank) m_lat = 1;
          m_line = nx;
        end
        m_vbl = (m_line >= a_blank);
        if (m_lat) begin
          a_min = p_min; a_max = p_max; a_flip = p_flip; a_ctl = p_ctl;
          a_blank = p_blank; a_tot = p_tot;
        end
      end
      if (cfg_wr) begin
        case (cfg_addr)
          3'd0: p_min = cfg_wdata & 'hFFF;
          3'd1: p_max = cfg_wdata & 'hFFF;
          3'd2: p_flip = cfg_wdata & 'hFFF;
          3'd3: p_ctl = cfg_wdata & 'hFFF;
          3'd4: begin m_pen = cfg_wdata[0]; m_send = cfg_wdata[0] & cfg_wdata[1]; end
          3'd5: p_blank = cfg_wdata & 'hFFF;
          3'd6: p_tot = cfg_wdata & 'hFFF;
          default: ;
        endcase
      end else if (cons) m_send = 0;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit vrr, err;
      int el, lo, hi, vmax;
      m_bounds(vrr, err, el, lo, hi, vmax);
      chk(line_num == LW'(m_line), "R2 line_num", int'(line_num), m_line);
      chk(frame_start == m_fs, "R2 frame_start", int'(frame_start), int'(m_fs));
      chk(vblank == m_vbl, "R3 vblank", int'(vblank), int'(m_vbl));
      chk(latch_stb == m_lat, "R12 latch_stb", int'(latch_stb), int'(m_lat));
      chk(cfg_error == err, "R10 cfg_error", int'(cfg_error), int'(err));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    cfg_addr = 3'(a);
    #1;
    chk(cfg_rdata == 32'(exp), req, int'(cfg_rdata), exp);
  endtask

  // runs one whole frame; optional write when the counter first shows wline
  task automatic run_frame(input int wline, input int wa, input int wd,
                           output int len, output int lat);
    int prev;
    bit wdone = 0;
    lat = -1; len = -1;
    do @(negedge clk); while (!frame_start);
    prev = int'(line_num);
    forever begin
      @(negedge clk);
      cfg_wr = 1'b0;
      if (frame_start) begin
        len = prev + 1;
        break;
      end
      if (latch_stb) lat = int'(line_num);
      prev = int'(line_num);
      if (!wdone && int'(line_num) == wline) begin
        cfg_wr = 1'b1; cfg_addr = 3'(wa); cfg_wdata = 32'(wd);
        wdone = 1;
      end
    end
  endtask

  task automatic frame(input int wline, input int wa, input int wd,
                       input int elen, input int elat, input string req);
    int len, lat;
    run_frame(wline, wa, wd, len, lat);
    chk(len == elen, {req, " frame length"}, len, elen);
    if (elat >= 0) chk(lat == elat, {req, " latch line"}, lat, elat);
  endtask

  task automatic skip_frame();
    int len, lat;
    run_frame(-1, 0, 0, len, lat);
  endtask

  // CONTROL word: en | flip_en<<1 | fsd_m1<<2 | guard<<4
  localparam int CTL_A = 1 + 2 + (1 << 2) + (4 << 4);   // exit 4+2+1 = 7
  localparam int CTL_B = 1 + 2 + (3 << 2) + (6 << 4);   // exit 6+4+1 = 11

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(line_num == '0, "R1 line_num", int'(line_num), 0);
    chk(!vblank && !frame_start && !latch_stb, "R1 strobes", int'(vblank), 0);
    chk(!cfg_error, "R1 cfg_error", int'(cfg_error), 0);
    rd_chk(5, 15, "R1 blank default");
    rd_chk(6, 19, "R1 total default");
    rd_chk(4, 0, "R1 push default");
    rd_chk(3, 0, "R1 control default");

    // R3 fixed timing with defaults
    frame(-1, 0, 0, 20, 15, "R3 fixed default");
    // R12 write after the latch line does not touch the running frame
    frame(17, 6, 23, 20, 15, "R12 shadowed total");
    frame(-1, 0, 0, 24, 15, "R3 new total");
    rd_chk(6, 23, "R11 total readback");

    // variable refresh: min 30, max 50, flip 31, blank 20
    wr(0, 29); wr(1, 49); wr(2, 30); wr(5, 20); wr(3, CTL_A); wr(4, 1);
    rd_chk(0, 29, "R11 minlen readback");
    rd_chk(1, 49, "R11 maxlen readback");
    rd_chk(2, 30, "R11 flipline readback");
    rd_chk(3, CTL_A, "R11 control readback");
    skip_frame();
    skip_frame();
    frame(-1, 0, 0, 50, 43, "R5 no push");
    frame(5, 4, 3, 31, 24, "R6 early push");
    rd_chk(4, 1, "R8 send self-clear");
    frame(30, 4, 3, 38, 31, "R7 push in window");
    rd_chk(4, 1, "R8 send cleared after window push");
    frame(5, 4, 2, 50, 43, "R9 send without enable");
    rd_chk(4, 0, "R9 push readback");
    wr(4, 1);

    // R4 flipline and exit length effect
    wr(2, 34);
    skip_frame();
    frame(5, 4, 3, 35, 28, "R4 flipline 35");
    wr(3, CTL_B);
    skip_frame();
    frame(5, 4, 3, 35, 24, "R4 exit 11 early");
    frame(-1, 0, 0, 50, 39, "R4 exit 11 late");

    // R10 invalid settings
    wr(2, 29);
    skip_frame();
    chk(cfg_error, "R10 flip below min", int'(cfg_error), 1);
    frame(-1, 0, 0, 24, 20, "R10 fixed fallback");
    wr(2, 34); wr(0, 49);
    skip_frame();
    chk(cfg_error, "R10 min equals max", int'(cfg_error), 1);
    wr(0, 29);
    skip_frame();
    chk(!cfg_error, "R10 valid again", int'(cfg_error), 0);

    // R12 disable
    wr(3, 0); wr(4, 0);
    skip_frame();
    frame(-1, 0, 0, 24, 20, "R12 back to fixed");
    rd_chk(4, 0, "R12 push cleared");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule